// File: doc/BRIEF.md
# Three-Port Register File with Hard-Wired Zero Entry

This block is the general-register store of a small 16-bit processor datapath. It holds eight 16-bit entries. Two read ports are combinational and one write port is clocked. The first read port always follows address field A. The second read port shows either field B or field C, chosen by a control line.

The write goes to the entry named by field C. A second control line can redirect it to entry 6, which acts as the exception-pointer register. A 2-bit select picks the write data from four buses: the incremented program counter, the ALU result, memory read data and the current program counter.

Entry 7 has no storage and always reads zero. A flag reports when the first read port carries all zeros. The ALU, memory and program-counter logic lie outside this block and reach it only as input buses.

Top module: `regfile3p`

## Requirements
- R1: On a rising clock edge with `wr_en` high, the selected data is stored into the target entry. That entry then reads back the stored value on both read ports.
- R2: Entry 7 always reads as 16'h0000 on both ports. A write aimed at entry 7 has no effect on any entry.
- R3: `port_a` shows the entry addressed by `ra_addr` combinationally, within the same cycle that the address changes.
- R4: With `rb_use_rc` = 0, `port_b` shows the entry addressed by `rb_addr`. With `rb_use_rc` = 1, it shows the entry addressed by `rc_addr`.
- R5: With `wr_force_exc` = 0, the write target is the entry addressed by `rc_addr`. With `wr_force_exc` = 1, the target is entry 6, whatever `rc_addr` holds.
- R6: While `wr_en` is low, no entry changes on a clock edge.
- R7: `wd_sel` selects the write data: 0 = `pc_next`, 1 = `alu_result`, 2 = `mem_data`, 3 = `pc_now`.
- R8: `a_is_zero` is 1 exactly when all 16 bits of `port_a` are 0.
- R9: A read of the entry being written in the same cycle returns the old value until the clock edge. It returns the new value after the edge.
- R10: A clock edge with `rst_n` low clears entries 0 to 6 to zero. This reset is synchronous and active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_addr | input | 3 | Address field A, drives read port A |
| rb_addr | input | 3 | Address field B |
| rc_addr | input | 3 | Address field C, the write address or the alternate port-B address |
| rb_use_rc | input | 1 | 1: port B reads field C; 0: port B reads field B |
| wr_force_exc | input | 1 | 1: write goes to entry 6 instead of field C |
| wr_en | input | 1 | Write enable |
| wd_sel | input | 2 | Write-data select (0 pc_next, 1 alu_result, 2 mem_data, 3 pc_now) |
| pc_next | input | 16 | Incremented program counter |
| alu_result | input | 16 | ALU result |
| mem_data | input | 16 | Memory read data |
| pc_now | input | 16 | Current program counter |
| port_a | output | 16 | Read port A data |
| port_b | output | 16 | Read port B data |
| a_is_zero | output | 1 | High when port_a is all zeros |

## Verification
Every entry is loaded with a distinct value, and all 64 pairs of A and B addresses are swept. A wrong decode therefore shows up as a value from the wrong entry, not merely as a missing change. Field C then addresses port B, which separates the two address sources of that port.

Writes use each of the four data selects in turn, with distinct bus values, so a swapped select code is caught. Writes aimed at entry 7, and writes made with the redirect line set and a field C that differs from 6, check where data lands. Cycles with the enable low, a same-cycle read of the entry being written, and a mid-run reset cover holding, read timing and clearing. Entries holding zero and non-zero values exercise both states of the zero flag.

// File: rtl/regfile_pkg.sv
// Package: shared sizes for the three-port register file.
// Assumes one write port and a power-of-two entry count.
package regfile_pkg;
    localparam int RF_DATA_W = 16;
    localparam int RF_ADDR_W = 3;
    localparam int RF_SRC_N  = 4;

    // Write-data source codes, in select order.
    typedef enum logic [1:0] {
        SRC_PC_NEXT = 2'd0,
        SRC_ALU     = 2'd1,
        SRC_MEM     = 2'd2,
        SRC_PC_NOW  = 2'd3
    } wd_src_e;
endpackage

// File: rtl/rf_wdata_mux.sv
// Module: four-input write-data selector.
// Does: forwards one of four buses according to the source code.
// Assumes: the select is always a defined 2-bit value.
module rf_wdata_mux
    import regfile_pkg::*;
#(
    parameter int DATA_W = RF_DATA_W
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] src_pc_next,
    input  logic [DATA_W-1:0] src_alu,
    input  logic [DATA_W-1:0] src_mem,
    input  logic [DATA_W-1:0] src_pc_now,
    output logic [DATA_W-1:0] wdata
);
    // Pick the write data by source code.
    always_comb begin
        unique case (wd_src_e'(sel))
            SRC_PC_NEXT: wdata = src_pc_next;
            SRC_ALU:     wdata = src_alu;
            SRC_MEM:     wdata = src_mem;
            default:     wdata = src_pc_now;
        endcase
    end
endmodule

// File: rtl/rf_store.sv
// Module: register storage with write-target selection.
// Does: holds entries 0 to NUM_REGS-2. The top entry is a constant zero.
//   The write goes to field C, or to EXC_REG when redirected.
// Assumes: EXC_REG is below the zero entry.
module rf_store
    import regfile_pkg::*;
#(
    parameter int DATA_W  = RF_DATA_W,
    parameter int ADDR_W  = RF_ADDR_W,
    parameter int EXC_REG = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_force_exc,
    input  logic [ADDR_W-1:0]               rc_addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [(2**ADDR_W)*DATA_W-1:0]   rf_flat
);
    localparam int NUM_REGS = 2 ** ADDR_W;
    localparam int ZERO_REG = NUM_REGS - 1;

    logic [ADDR_W-1:0] wr_tgt;
    logic [DATA_W-1:0] rf [NUM_REGS];

    // Resolve the write target: field C, or the exception-pointer entry.
    always_comb wr_tgt = wr_force_exc ? ADDR_W'(EXC_REG) : rc_addr;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        if (i == ZERO_REG) begin : g_zero
            // The top entry has no storage.
            assign rf[i] = '0;
        end else begin : g_reg
            // Store one entry: clear on reset, load when targeted.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rf[i] <= '0;
                else if (wr_en && wr_tgt == ADDR_W'(i))
                    rf[i] <= wdata;
            end

            AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(rf[i])); // R6

            AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wr_force_exc && rc_addr == ADDR_W'(i)) |=> rf[i] == $past(wdata)); // R1
        end
        assign rf_flat[i*DATA_W +: DATA_W] = rf[i];
    end

    AST_EXC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_force_exc) |=> rf_flat[EXC_REG*DATA_W +: DATA_W] == $past(wdata)); // R5

    AST_ZERO_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rf_flat[ZERO_REG*DATA_W +: DATA_W] == '0); // R2
endmodule

// File: rtl/rf_read_mux.sv
// Module: combinational read port.
// Does: returns the entry named by the address from the flattened storage.
// Assumes: the address is always in range (full power-of-two decode).
module rf_read_mux
    import regfile_pkg::*;
#(
    parameter int DATA_W = RF_DATA_W,
    parameter int ADDR_W = RF_ADDR_W
) (
    input  logic [(2**ADDR_W)*DATA_W-1:0] rf_flat,
    input  logic [ADDR_W-1:0]             addr,
    output logic [DATA_W-1:0]             rdata
);
    // Select the addressed entry with no clock delay.
    always_comb rdata = rf_flat[addr*DATA_W +: DATA_W];
endmodule

// File: rtl/regfile3p.sv
// Module: top of the three-port register file.
// Does: muxes the write data, stores it, and serves two read ports.
//   Port B reads field B or field C. It also flags an all-zero port A.
// Assumes: a single clock and a synchronous active-low reset.
module regfile3p
    import regfile_pkg::*;
#(
    parameter int DATA_W  = RF_DATA_W,
    parameter int ADDR_W  = RF_ADDR_W,
    parameter int EXC_REG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic [ADDR_W-1:0] rb_addr,
    input  logic [ADDR_W-1:0] rc_addr,
    input  logic              rb_use_rc,
    input  logic              wr_force_exc,
    input  logic              wr_en,
    input  logic [1:0]        wd_sel,
    input  logic [DATA_W-1:0] pc_next,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] pc_now,
    output logic [DATA_W-1:0] port_a,
    output logic [DATA_W-1:0] port_b,
    output logic              a_is_zero
);
    localparam int NUM_REGS = 2 ** ADDR_W;
    localparam int ZERO_REG = NUM_REGS - 1;

    logic [DATA_W-1:0]          wdata;
    logic [NUM_REGS*DATA_W-1:0] rf_flat;
    logic [ADDR_W-1:0]          pb_addr;

    rf_wdata_mux #(.DATA_W(DATA_W)) u_wmux (
        .sel(wd_sel), .src_pc_next(pc_next), .src_alu(alu_result),
        .src_mem(mem_data), .src_pc_now(pc_now), .wdata(wdata)
    );

    rf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .EXC_REG(EXC_REG)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_force_exc(wr_force_exc),
        .rc_addr(rc_addr), .wdata(wdata), .rf_flat(rf_flat)
    );

    // Choose the port-B address field.
    always_comb pb_addr = rb_use_rc ? rc_addr : rb_addr;

    rf_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
        .rf_flat(rf_flat), .addr(ra_addr), .rdata(port_a)
    );

    rf_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
        .rf_flat(rf_flat), .addr(pb_addr), .rdata(port_b)
    );

    // Flag an all-zero port A.
    always_comb a_is_zero = ~|port_a;

    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        ra_addr == ADDR_W'(ZERO_REG) |-> port_a == '0); // R2

    AST_ZFLAG_ON_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ra_addr == ADDR_W'(ZERO_REG) |-> a_is_zero); // R8

    AST_PORTB_FIELD_C: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_use_rc && ra_addr == rc_addr) |-> port_b == port_a); // R4

    AST_PORTB_FIELD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_use_rc && ra_addr == rb_addr) |-> port_b == port_a); // R4
endmodule

// File: tb/regfile3p_test.sv
// Bench: near-exhaustive sweep of the register file against a model array.
module regfile3p_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  ra_addr, rb_addr, rc_addr;
    logic        rb_use_rc, wr_force_exc, wr_en;
    logic [1:0]  wd_sel;
    logic [15:0] pc_next, alu_result, mem_data, pc_now;
    logic [15:0] port_a, port_b;
    logic        a_is_zero;

    logic [15:0] model [8];
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk; // 125 MHz

    regfile3p uut (
        .clk(clk), .rst_n(rst_n), .ra_addr(ra_addr), .rb_addr(rb_addr),
        .rc_addr(rc_addr), .rb_use_rc(rb_use_rc), .wr_force_exc(wr_force_exc),
        .wr_en(wr_en), .wd_sel(wd_sel), .pc_next(pc_next), .alu_result(alu_result),
        .mem_data(mem_data), .pc_now(pc_now), .port_a(port_a), .port_b(port_b),
        .a_is_zero(a_is_zero)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(input logic [1:0] s);
        case (s)
            2'd0: return pc_next;
            2'd1: return alu_result;
            2'd2: return mem_data;
            default: return pc_now;
        endcase
    endfunction

    // One write cycle: drive at a falling edge, the rising edge stores.
    task automatic wr(input logic we, input logic frc, input logic [2:0] rc,
                      input logic [1:0] s, input logic [15:0] seed);
        logic [2:0] t;
        pc_next = seed ^ 16'h0101; alu_result = seed ^ 16'h2020;
        mem_data = seed ^ 16'h0404; pc_now = seed ^ 16'h8008;
        wr_en = we; wr_force_exc = frc; rc_addr = rc; wd_sel = s;
        t = frc ? 3'd6 : rc;
        @(negedge clk);
        if (we && t != 3'd7) model[t] = pick(s);
        wr_en = 1'b0; wr_force_exc = 1'b0;
    endtask

    // Sweep every A/B address pair and every field-C address on port B.
    task automatic sweep(input string tag);
        rb_use_rc = 1'b0;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                ra_addr = 3'(a); rb_addr = 3'(b);
                #1;
                chk({tag, " R3 port_a"}, port_a, model[a]);
                chk({tag, " R4 port_b via B"}, port_b, model[b]);
                chk({tag, " R8 zero flag"}, {15'd0, a_is_zero}, {15'd0, model[a] == 16'h0});
            end
        end
        rb_use_rc = 1'b1; rb_addr = 3'd0;
        for (int c = 0; c < 8; c++) begin
            rc_addr = 3'(c);
            #1;
            chk({tag, " R4 port_b via C"}, port_b, model[c]);
        end
        rb_use_rc = 1'b0;
    endtask

    initial begin
        #150000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 16'h0;
        rst_n = 1'b0; wr_en = 1'b0; wr_force_exc = 1'b0; rb_use_rc = 1'b0;
        wd_sel = 2'd0; ra_addr = 3'd0; rb_addr = 3'd0; rc_addr = 3'd0;
        pc_next = 16'h0; alu_result = 16'h0; mem_data = 16'h0; pc_now = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R10 reset state");

        // R1 R7: load entries 0..7 via field C, cycling all four sources.
        for (int i = 0; i < 8; i++) wr(1'b1, 1'b0, 3'(i), 2'(i % 4), 16'h1357 * 16'(i + 1));
        sweep("R1 R7 R2 after loads");

        // R7: each select code into entry 3, read back.
        for (int s = 0; s < 4; s++) begin
            wr(1'b1, 1'b0, 3'd3, 2'(s), 16'hA5C3 + 16'(s));
            ra_addr = 3'd3; #1;
            chk("R7 select code", port_a, (16'hA5C3 + 16'(s)) ^
                (s == 0 ? 16'h0101 : s == 1 ? 16'h2020 : s == 2 ? 16'h0404 : 16'h8008));
        end

        // R5: redirect to entry 6 with field C on 2.
        wr(1'b1, 1'b1, 3'd2, 2'd1, 16'h6E6E);
        sweep("R5 redirect");

        // R6: enable low, busy buses.
        for (int i = 0; i < 8; i++) wr(1'b0, 1'(i % 2), 3'(i), 2'(i % 4), 16'hFFFF);
        sweep("R6 hold");

        // R2: write entry 7 explicitly, all entries unchanged.
        wr(1'b1, 1'b0, 3'd7, 2'd2, 16'hBEEF);
        sweep("R2 zero entry write");

        // R8: store zero in entry 1.
        wr(1'b1, 1'b0, 3'd1, 2'd1, 16'h2020);
        sweep("R8 zero value");

        // R9: read-during-write returns old value before the edge.
        ra_addr = 3'd4;
        pc_next = 16'h4444 ^ 16'h0101; wd_sel = 2'd0;
        rc_addr = 3'd4; wr_en = 1'b1; #1;
        chk("R9 old value before edge", port_a, model[4]);
        @(negedge clk);
        model[4] = 16'h4444 ^ 16'h0101;
        wr_en = 1'b0; #1;
        chk("R9 new value after edge", port_a, 16'h4444 ^ 16'h0101);

        // R10: mid-run reset clears all entries.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = 16'h0;
        sweep("R10 mid-run reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule